// File: doc/BRIEF.md
# Direct-Mapped Write-Through Word Cache

This block sits between a processor's word-wide load/store port and a slower main memory. It holds a small table of lines, each with one data word, a tag and a valid bit. The line is chosen by the low-order bits of the word address. The rest of the address is the tag, which one equality comparator checks against the tag stored in that line. Loads that hit are answered from the table. Loads that miss stall the processor while the word is fetched, and the fetched word then replaces the line.

Every store goes out to memory. A store that misses still claims its line: the new tag and data go straight into the table, because the whole line is the stored word and nothing needs to be fetched. The processor port is stalled until memory acknowledges the store.

The controller has three states. IDLE accepts requests. FETCH waits for a memory read. STORE waits for a memory write. The transitions are:
- IDLE to FETCH on an accepted load that misses.
- IDLE to STORE on any accepted store.
- FETCH to IDLE on acknowledge.
- STORE to IDLE on acknowledge.
- IDLE stays in IDLE on a load hit or when there is no request.

Top module: `wt_dm_cache`

## Requirements
- R1: After reset `cpu_ready` is 1, `mem_req` is 0, and every line is invalid. The first load to any address therefore misses and issues one memory read.
- R2: A load accepted (`cpu_req`=1, `cpu_we`=0, `cpu_ready`=1) that hits drives `cpu_rvalid`=1 with the stored word on `cpu_rdata` in the next cycle. It issues no memory access.
- R3: A load that misses raises `mem_req` with `mem_we`=0 and `mem_addr` equal to the load address. In the cycle after `mem_ack`, `cpu_rvalid`=1 and `cpu_rdata` equals `mem_rdata` as sampled at the acknowledge. The line is installed, so a repeat load of that address hits.
- R4: A store that hits updates the line and issues a memory write (`mem_we`=1) with the same address and word. A later load of that address hits and returns the new word.
- R5: A store that misses issues a memory write and no memory read. It installs the line with the store's tag and word, so a later load of that address hits without a memory read.
- R6: The index is the low `IDX_W` bits of the word address (4 by default). Two addresses that differ only above those bits share a line and evict each other. Addresses with different index bits do not disturb each other.
- R7: While `mem_req`=1 and `mem_ack`=0, the signals `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged into the next cycle.
- R8: `cpu_ready` is 0 whenever a memory access is outstanding (`mem_req`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, taken when `cpu_ready` is 1 |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store word |
| cpu_ready | output | 1 | Cache can accept a request |
| cpu_rvalid | output | 1 | Load result valid (one-cycle pulse) |
| cpu_rdata | output | DATA_W | Load result |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write word |
| mem_ack | input | 1 | Memory completes the access (one-cycle pulse) |
| mem_rdata | input | DATA_W | Memory read word, valid with `mem_ack` |

## Verification
The assertions assume three things about the inputs. Memory raises `mem_ack` only while `mem_req` is high, and only for one cycle. The processor presents requests only while `cpu_ready` is high. The processor keeps `cpu_req` low otherwise. The stimulus meets these assumptions in three ways. Each request is driven only after `cpu_ready` is seen high, and it is dropped after one accepting edge. The memory model acknowledges once per request, after a fixed two-cycle wait, and drops the acknowledge in the following cycle.

// File: rtl/wt_dm_cache_pkg.sv
package wt_dm_cache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_STORE = 2'd2
    } cache_state_e;
endpackage

// File: rtl/wt_dm_line_store.sv
module wt_dm_line_store #(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_index,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_word,
    input  logic              up_en,
    input  logic [IDX_W-1:0]  up_index,
    input  logic [TAG_W-1:0]  up_tag,
    input  logic [DATA_W-1:0] up_word
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0]  line_valid;
    logic [TAG_W-1:0]  tag_tab  [LINES];
    logic [DATA_W-1:0] word_tab [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_valid[g] <= 1'b0;
            end else if (up_en && up_index == IDX_W'(g)) begin
                line_valid[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (up_en && up_index == IDX_W'(g)) begin
                tag_tab[g]  <= up_tag;
                word_tab[g] <= up_word;
            end
        end
    end

    always_comb begin
        lk_hit  = line_valid[lk_index] && (tag_tab[lk_index] == lk_tag);
        lk_word = word_tab[lk_index];
    end
endmodule

// File: rtl/wt_dm_ctrl.sv
module wt_dm_ctrl
    import wt_dm_cache_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              lk_hit,
    input  logic [DATA_W-1:0] lk_word,
    output logic              up_en,
    output logic [ADDR_W-1:0] up_addr,
    output logic [DATA_W-1:0] up_word,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    cache_state_e      state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              rvalid_q;
    logic [DATA_W-1:0] rdata_q;
    logic              accept;

    assign accept = cpu_req && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && cpu_we)           state_d = ST_STORE;
                else if (accept && !lk_hit)     state_d = ST_FETCH;
            end
            ST_FETCH: if (mem_ack) state_d = ST_IDLE;
            ST_STORE: if (mem_ack) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            wdata_q  <= '0;
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            state_q  <= state_d;
            rvalid_q <= 1'b0;
            if (accept) begin
                addr_q  <= cpu_addr;
                wdata_q <= cpu_wdata;
                if (!cpu_we && lk_hit) begin
                    rvalid_q <= 1'b1;
                    rdata_q  <= lk_word;
                end
            end
            if (state_q == ST_FETCH && mem_ack) begin
                rvalid_q <= 1'b1;
                rdata_q  <= mem_rdata;
            end
        end
    end

    always_comb begin
        cpu_ready  = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        up_en      = 1'b0;
        up_addr    = cpu_addr;
        up_word    = cpu_wdata;
        unique case (state_q)
            ST_IDLE: begin
                cpu_ready = 1'b1;
                up_en     = accept && cpu_we;
            end
            ST_FETCH: begin
                mem_req = 1'b1;
                up_en   = mem_ack;
                up_addr = addr_q;
                up_word = mem_rdata;
            end
            ST_STORE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
        mem_addr   = addr_q;
        mem_wdata  = wdata_q;
        cpu_rvalid = rvalid_q;
        cpu_rdata  = rdata_q;
    end

    // R2
    read_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && !cpu_we && lk_hit) |=>
            (cpu_rvalid && !mem_req && cpu_rdata == $past(lk_word)));
    // R3
    fill_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=>
            (cpu_rvalid && cpu_rdata == $past(mem_rdata)));
    // R5
    store_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && cpu_we) |=>
            (mem_req && mem_we && mem_addr == $past(cpu_addr) && mem_wdata == $past(cpu_wdata)));
    // R7
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=>
            (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));
    // R8
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);
endmodule

// File: rtl/wt_dm_cache.sv
module wt_dm_cache #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic              lk_hit;
    logic [DATA_W-1:0] lk_word;
    logic              up_en;
    logic [ADDR_W-1:0] up_addr;
    logic [DATA_W-1:0] up_word;

    wt_dm_line_store #(
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_index (cpu_addr[IDX_W-1:0]),
        .lk_tag   (cpu_addr[ADDR_W-1:IDX_W]),
        .lk_hit   (lk_hit),
        .lk_word  (lk_word),
        .up_en    (up_en),
        .up_index (up_addr[IDX_W-1:0]),
        .up_tag   (up_addr[ADDR_W-1:IDX_W]),
        .up_word  (up_word)
    );

    wt_dm_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_ready  (cpu_ready),
        .cpu_rvalid (cpu_rvalid),
        .cpu_rdata  (cpu_rdata),
        .lk_hit     (lk_hit),
        .lk_word    (lk_word),
        .up_en      (up_en),
        .up_addr    (up_addr),
        .up_word    (up_word),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata)
    );
endmodule

// File: tb/sim_wt_dm_cache.sv
module sim_wt_dm_cache;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ready, cpu_rvalid;
    logic [DW-1:0] cpu_rdata;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    int total = 0;
    int bad = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    bit done = 0;

    logic [DW-1:0] exp_q [$];
    logic [DW-1:0] ref_mem [logic [AW-1:0]];
    bit            mv [1<<IW];
    logic [AW-IW-1:0] mt [1<<IW];
    logic [AW-1:0] exp_addr;
    logic [DW-1:0] exp_wd;
    string         cur_rq = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    wt_dm_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [DW-1:0] mem_val(logic [AW-1:0] a);
        if (ref_mem.exists(a)) return ref_mem[a];
        return {16'hC0DE, a};
    endfunction

    task automatic check(bit ok, string rq, string what, longint act, longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // memory model: acknowledges after two waiting cycles
    initial begin
        int wait_c = 0;
        forever begin
            @(negedge clk);
            if (mem_req && cpu_ready) check(0, "R8", "ready while memory busy", 1, 0);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (wait_c == 2) begin
                    wait_c = 0;
                    mem_ack = 1'b1;
                    check(mem_addr == exp_addr, cur_rq, "R7 mem_addr", mem_addr, exp_addr);
                    if (mem_we) begin
                        wr_cnt++;
                        check(mem_wdata == exp_wd, cur_rq, "mem_wdata", mem_wdata, exp_wd);
                    end else begin
                        rd_cnt++;
                        mem_rdata = mem_val(mem_addr);
                    end
                end else begin
                    wait_c++;
                end
            end
        end
    end

    // monitor: pops expected load results
    initial begin
        forever begin
            @(negedge clk);
            if (cpu_rvalid) begin
                if (exp_q.size() == 0) begin
                    check(0, cur_rq, "unexpected rvalid", 1, 0);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    check(cpu_rdata == e, cur_rq, "cpu_rdata", cpu_rdata, e);
                end
            end
        end
    end

    task automatic do_op(bit we, logic [AW-1:0] a, logic [DW-1:0] d, string rq);
        int r0, w0, qn;
        bit miss;
        logic [IW-1:0] idx;
        logic [AW-IW-1:0] tg;
        idx = a[IW-1:0];
        tg  = a[AW-1:IW];
        while (!cpu_ready) @(negedge clk);
        cur_rq = rq;
        miss = !(mv[idx] && mt[idx] == tg);
        r0 = rd_cnt;
        w0 = wr_cnt;
        exp_addr = a;
        if (we) begin
            exp_wd = d;
            ref_mem[a] = d;
        end else begin
            exp_q.push_back(mem_val(a));
        end
        mv[idx] = 1'b1;
        mt[idx] = tg;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 1'b0;
        while (!cpu_ready) @(negedge clk);
        @(negedge clk);
        qn = exp_q.size();
        check(qn == 0, rq, "result not returned", qn, 0);
        exp_q.delete();
        check(rd_cnt - r0 == ((!we && miss) ? 1 : 0), rq, "memory reads", rd_cnt - r0, (!we && miss) ? 1 : 0);
        check(wr_cnt - w0 == (we ? 1 : 0), rq, "memory writes", wr_cnt - w0, we ? 1 : 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(0, "watchdog", "run hung", 0, 1);
            summary();
        end
    end

    initial begin
        for (int i = 0; i < (1 << IW); i++) mv[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cpu_ready == 1'b1, "R1", "cpu_ready after reset", cpu_ready, 1);
        check(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);
        check(cpu_rvalid == 1'b0, "R1", "cpu_rvalid after reset", cpu_rvalid, 0);

        do_op(0, 16'h0005, '0, "R1");          // invalid line misses
        do_op(0, 16'h0005, '0, "R2");          // hit
        do_op(0, 16'h0033, '0, "R3");          // miss, fill
        do_op(0, 16'h0033, '0, "R3");          // now hits
        do_op(1, 16'h0005, 32'hDEAD_0005, "R4"); // write hit
        do_op(0, 16'h0005, '0, "R4");
        do_op(1, 16'h0127, 32'h1234_5678, "R5"); // write miss allocates
        do_op(0, 16'h0127, '0, "R5");
        do_op(0, 16'h0015, '0, "R6");          // same index as 0x0005
        do_op(0, 16'h0005, '0, "R6");          // evicted, misses again
        do_op(0, 16'h0127, '0, "R6");          // other index untouched
        do_op(1, 16'h0105, 32'hAAAA_5555, "R6"); // write miss evicts 0x0005
        do_op(0, 16'h0005, '0, "R6");
        for (int i = 0; i < (1 << IW); i++) do_op(0, AW'(16'h0200 + i), '0, "R3");
        for (int i = 0; i < (1 << IW); i++) do_op(0, AW'(16'h0200 + i), '0, "R2");
        for (int i = 0; i < (1 << IW); i += 3) do_op(1, AW'(16'h0400 + i), DW'(32'h5000 + i), "R5");
        for (int i = 0; i < (1 << IW); i++) do_op(0, AW'(16'h0400 + i), '0, "R7");
        done = 1;
        summary();
    end
endmodule